// File: doc/BRIEF.md
# Dual-Phase Serial Frame Transmitter

This block turns parallel sample words into a serial bit stream, one bit per bit-clock step, framed by an external frame-sync strobe. The bit clock and the frame sync come from outside. The block receives them as single-cycle strobes in the system clock domain, one strobe for each bit-clock edge. Configuration picks which edge launches data. A frame holds one or two phases. Each phase has its own word length and its own element count, so one frame can carry, for example, one short control word and then several long audio words. A stereo pair can also travel as a single double-width element.

Words enter through a one-deep holding register with a valid/ready handshake. Each element is sent MSB first, using the low bits of the word. When a new element starts and no fresh word is waiting, the last word sent is repeated and a sticky underrun flag is raised. A frame sync that arrives in the middle of a frame does one of two things, set by configuration: it is ignored, or it restarts the frame and sets a sticky sync-error flag. While the transmitter enable is low, the line stays low and both flags are cleared.

Top module: `sft_dual_phase_tx`

## Requirements
- R1: Each word-length code selects the bits per element: code 0 gives 8, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5 gives 32. Codes 6 and 7 also give 32.
- R2: Each phase's element count is programmed as the number of elements minus one.
- R3: With the dual-phase bit set, a frame sends all phase-1 elements and then all phase-2 elements, each phase using its own length and count. With the bit clear, only phase 1 is sent.
- R4: With data delay 1, the output is low on the step at which frame sync is seen, and the first data bit comes one step later. With delay 0, the first data bit is launched on the frame-sync step itself.
- R5: With the ignore bit set, a frame sync seen during a frame has no effect: the bits continue and no error is flagged.
- R6: With the ignore bit clear, a frame sync seen during a frame sets a sticky sync-error flag and restarts the frame. A frame sync on the step right after the last bit starts the next frame without an error.
- R7: While the transmitter enable is low, the output is low, frame syncs start nothing, and both flags read 0. After the enable is raised, the next frame sync starts a frame.
- R8: With launch-on-fall set, only the falling-edge strobe advances the output. With it clear, only the rising-edge strobe does. The other strobe changes nothing.
- R9: With the active-low sync bit set, the frame sync is active when the input is 0. With the bit clear, it is active when the input is 1.
- R10: If no word is waiting when an element starts, the previously loaded word is sent again and a sticky underrun flag is set.
- R11: Each element is sent MSB first from the low-order bits of its word. The output is low in every step outside a frame.
- R12: `in_ready` is high exactly when the holding register is empty. A word is taken on a cycle where `in_valid` and `in_ready` are both high, and the start of an element empties the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; low holds the block idle and clears the flags |
| cfg_wlen1 | input | 3 | Phase-1 word-length code |
| cfg_wlen2 | input | 3 | Phase-2 word-length code |
| cfg_cnt1 | input | CNT_W | Phase-1 element count minus one |
| cfg_cnt2 | input | CNT_W | Phase-2 element count minus one |
| cfg_dual | input | 1 | Enables the second phase |
| cfg_delay | input | 1 | Data delay after frame sync (0 or 1 bit) |
| cfg_fs_ignore | input | 1 | Ignore frame syncs that arrive during a frame |
| cfg_fs_low | input | 1 | Frame sync is active low |
| cfg_launch_fall | input | 1 | Launch data on the falling-edge strobe |
| bit_rise | input | 1 | One-cycle strobe at each rising bit-clock edge |
| bit_fall | input | 1 | One-cycle strobe at each falling bit-clock edge |
| fsync | input | 1 | Frame-sync level, sampled on the launch strobe |
| in_valid | input | 1 | Input word valid |
| in_data | input | WORD_W | Input word, right-aligned |
| in_ready | output | 1 | Holding register empty |
| sdo | output | 1 | Serial data output |
| sync_err | output | 1 | Sticky unexpected-frame-sync flag |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The serial output and both flags come from registers. They update on the clock edge where the selected launch strobe is high, so each result is due one cycle after the strobe cycle. The bench raises every strobe at a falling clock edge and holds it for exactly one cycle. It then reads the output at the next falling edge, after the update edge has passed and before any later step. `in_ready` falls one cycle after an accepted word and rises one cycle after the strobe that starts an element. The bench tests it at falling edges as well. For a strobe that must have no effect, the bench compares the output at the falling edge after that strobe with its value just before.

// File: rtl/sft_pkg.sv
package sft_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LEAD = 2'd1,
      ST_DATA = 2'd2
   } seq_state_t;

   localparam int NUM_LEN_CODES = 6;

   // bits per element for a 3-bit length code; codes above 5 map to 32
   function automatic int code_len(input logic [2:0] code);
      case (code)
         3'd0:    return 8;
         3'd1:    return 12;
         3'd2:    return 16;
         3'd3:    return 20;
         3'd4:    return 24;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/sft_strobe_sel.sv
module sft_strobe_sel (
   input  logic bit_rise,
   input  logic bit_fall,
   input  logic launch_fall,
   input  logic fsync,
   input  logic fs_low,
   output logic tick,
   output logic fs_hit
);

   assign tick   = launch_fall ? bit_fall : bit_rise;
   assign fs_hit = tick & (fsync ^ fs_low);

endmodule

// File: rtl/sft_word_buf.sv
module sft_word_buf #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   input  logic              take,
   output logic [WORD_W-1:0] word,
   output logic              miss
);

   logic              hold_v;
   logic [WORD_W-1:0] hold_d;
   logic [WORD_W-1:0] last_d;
   logic              accept;

   assign in_ready = ~hold_v;
   assign accept   = in_valid & ~hold_v;
   assign word     = hold_v ? hold_d : last_d;
   assign miss     = take & ~hold_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         hold_d <= '0;
         last_d <= '0;
      end else begin
         if (take && hold_v) begin
            hold_v <= 1'b0;
            last_d <= hold_d;
         end
         if (accept) begin
            hold_v <= 1'b1;
            hold_d <= in_data;
         end
      end
   end

endmodule

// File: rtl/sft_frame_seq.sv
module sft_frame_seq
   import sft_pkg::*;
#(
   parameter int CNT_W = 7,
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             fs_hit,
   input  logic             cfg_dual,
   input  logic             cfg_delay,
   input  logic             cfg_ignore,
   input  logic [CNT_W-1:0] cnt1,
   input  logic [CNT_W-1:0] cnt2,
   input  logic [LEN_W-1:0] len1,
   input  logic [LEN_W-1:0] len2,
   output logic             load,
   output logic             load_ph2,
   output logic             shift,
   output logic             zero,
   output logic             fault
);

   seq_state_t       state_q;
   logic             phase_q;
   logic [CNT_W-1:0] elem_q;
   logic [LEN_W-1:0] bit_q;
   logic             bits_done, elems_done, frame_end, busy, start;

   always_comb begin
      bits_done  = (bit_q == '0);
      elems_done = (elem_q == '0);
      frame_end  = (state_q == ST_DATA) && bits_done && elems_done && (phase_q || !cfg_dual);
      busy       = (state_q != ST_IDLE) && !frame_end;
      start      = fs_hit && (!busy || !cfg_ignore);
   end

   assign fault    = en && fs_hit && busy && !cfg_ignore;
   assign load     = en && tick &&
                     ((start && !cfg_delay) ||
                      (!start && state_q == ST_LEAD) ||
                      (!start && state_q == ST_DATA && bits_done && !frame_end));
   assign load_ph2 = !start && (state_q == ST_DATA) && (elems_done || phase_q);
   assign shift    = en && tick && !start && (state_q == ST_DATA) && !bits_done;
   assign zero     = !en || (tick && ((start && cfg_delay) ||
                     (!start && (state_q == ST_IDLE || frame_end))));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= 1'b0;
         elem_q  <= '0;
         bit_q   <= '0;
      end else if (!en) begin
         state_q <= ST_IDLE;
         phase_q <= 1'b0;
         elem_q  <= '0;
         bit_q   <= '0;
      end else if (tick) begin
         if (start) begin
            phase_q <= 1'b0;
            elem_q  <= cnt1;
            if (cfg_delay) begin
               state_q <= ST_LEAD;
            end else begin
               state_q <= ST_DATA;
               bit_q   <= len1 - 1'b1;
            end
         end else begin
            case (state_q)
               ST_LEAD: begin
                  state_q <= ST_DATA;
                  bit_q   <= len1 - 1'b1;
               end
               ST_DATA: begin
                  if (frame_end) begin
                     state_q <= ST_IDLE;
                  end else if (bits_done) begin
                     if (elems_done) begin
                        phase_q <= 1'b1;
                        elem_q  <= cnt2;
                        bit_q   <= len2 - 1'b1;
                     end else begin
                        elem_q  <= elem_q - 1'b1;
                        bit_q   <= (phase_q ? len2 : len1) - 1'b1;
                     end
                  end else begin
                     bit_q <= bit_q - 1'b1;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/sft_shift_out.sv
module sft_shift_out
   import sft_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              zero,
   input  logic              load,
   input  logic              shift,
   input  logic [2:0]        len_code,
   input  logic [WORD_W-1:0] word,
   output logic              sdo
);

   logic [WORD_W-1:0] cand [NUM_LEN_CODES];
   logic [WORD_W-1:0] aligned;
   logic [WORD_W-1:0] sreg;

   // one left-aligned copy of the word per length code
   for (genvar c = 0; c < NUM_LEN_CODES; c++) begin : g_align
      localparam int SH = WORD_W - code_len(3'(c));
      assign cand[c] = word << SH;
   end

   always_comb begin
      case (len_code)
         3'd0:    aligned = cand[0];
         3'd1:    aligned = cand[1];
         3'd2:    aligned = cand[2];
         3'd3:    aligned = cand[3];
         3'd4:    aligned = cand[4];
         default: aligned = cand[5];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdo  <= 1'b0;
         sreg <= '0;
      end else if (zero) begin
         sdo  <= 1'b0;
      end else if (load) begin
         sdo  <= aligned[WORD_W-1];
         sreg <= aligned << 1;
      end else if (shift) begin
         sdo  <= sreg[WORD_W-1];
         sreg <= sreg << 1;
      end
   end

endmodule

// File: rtl/sft_dual_phase_tx.sv
module sft_dual_phase_tx
   import sft_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic [2:0]        cfg_wlen1,
   input  logic [2:0]        cfg_wlen2,
   input  logic [CNT_W-1:0]  cfg_cnt1,
   input  logic [CNT_W-1:0]  cfg_cnt2,
   input  logic              cfg_dual,
   input  logic              cfg_delay,
   input  logic              cfg_fs_ignore,
   input  logic              cfg_fs_low,
   input  logic              cfg_launch_fall,
   input  logic              bit_rise,
   input  logic              bit_fall,
   input  logic              fsync,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   output logic              sdo,
   output logic              sync_err,
   output logic              underrun
);

   localparam int LEN_W = $clog2(WORD_W) + 1;

   if (WORD_W < 32) begin : g_bad_word_w
      $error("sft_dual_phase_tx: WORD_W must be at least 32");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
      $error("sft_dual_phase_tx: CNT_W must be 1..16");
   end

   logic              tick, fs_hit;
   logic              load, load_ph2, shift, zero, fault, miss;
   logic [LEN_W-1:0]  len1, len2;
   logic [WORD_W-1:0] word;
   logic [2:0]        len_code;

   assign len1     = LEN_W'(code_len(cfg_wlen1));
   assign len2     = LEN_W'(code_len(cfg_wlen2));
   assign len_code = load_ph2 ? cfg_wlen2 : cfg_wlen1;

   sft_strobe_sel u_strobe (
      .bit_rise    (bit_rise),
      .bit_fall    (bit_fall),
      .launch_fall (cfg_launch_fall),
      .fsync       (fsync),
      .fs_low      (cfg_fs_low),
      .tick        (tick),
      .fs_hit      (fs_hit)
   );

   sft_frame_seq #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (tx_en),
      .tick       (tick),
      .fs_hit     (fs_hit),
      .cfg_dual   (cfg_dual),
      .cfg_delay  (cfg_delay),
      .cfg_ignore (cfg_fs_ignore),
      .cnt1       (cfg_cnt1),
      .cnt2       (cfg_cnt2),
      .len1       (len1),
      .len2       (len2),
      .load       (load),
      .load_ph2   (load_ph2),
      .shift      (shift),
      .zero       (zero),
      .fault      (fault)
   );

   sft_word_buf #(.WORD_W(WORD_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_ready (in_ready),
      .take     (load),
      .word     (word),
      .miss     (miss)
   );

   sft_shift_out #(.WORD_W(WORD_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .zero     (zero),
      .load     (load),
      .shift    (shift),
      .len_code (len_code),
      .word     (word),
      .sdo      (sdo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_err <= 1'b0;
         underrun <= 1'b0;
      end else if (!tx_en) begin
         sync_err <= 1'b0;
         underrun <= 1'b0;
      end else begin
         if (fault) sync_err <= 1'b1;
         if (miss)  underrun <= 1'b1;
      end
   end

endmodule

// File: rtl/sft_dual_phase_tx_chk.sv
module sft_dual_phase_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic tick,
   input logic cfg_fs_ignore,
   input logic in_valid,
   input logic in_ready,
   input logic sdo,
   input logic sync_err,
   input logic underrun
);

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> !sdo);                                   // R7
   AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (!sync_err && !underrun));               // R7
   AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !tick) |=> $stable(sdo));                 // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_err && tx_en) |=> sync_err);                  // R6
   AST_IGNORE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_err) |-> !$past(cfg_fs_ignore));         // R5
   AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && tx_en) |=> underrun);                  // R10
   AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> in_ready);              // R12
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && !tick) |=> !in_ready);                // R12

endmodule

bind sft_dual_phase_tx sft_dual_phase_tx_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tx_en         (tx_en),
   .tick          (tick),
   .cfg_fs_ignore (cfg_fs_ignore),
   .in_valid      (in_valid),
   .in_ready      (in_ready),
   .sdo           (sdo),
   .sync_err      (sync_err),
   .underrun      (underrun)
);

// File: tb/sim_sft_dual_phase_tx.sv
`timescale 1ns/1ps
module sim_sft_dual_phase_tx;

   localparam int WORD_W = 32;
   localparam int CNT_W  = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tx_en = 1'b0;
   logic [2:0]        cfg_wlen1 = 3'd0, cfg_wlen2 = 3'd0;
   logic [CNT_W-1:0]  cfg_cnt1 = '0, cfg_cnt2 = '0;
   logic              cfg_dual = 1'b0, cfg_delay = 1'b0, cfg_fs_ignore = 1'b0;
   logic              cfg_fs_low = 1'b0, cfg_launch_fall = 1'b0;
   logic              bit_rise = 1'b0, bit_fall = 1'b0, fsync = 1'b0;
   logic              in_valid = 1'b0;
   logic [WORD_W-1:0] in_data = '0;
   logic              in_ready, sdo, sync_err, underrun;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;
   logic [31:0] wq [8];

   always #2.5 clk = ~clk;

   sft_dual_phase_tx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
      .cfg_wlen1(cfg_wlen1), .cfg_wlen2(cfg_wlen2),
      .cfg_cnt1(cfg_cnt1), .cfg_cnt2(cfg_cnt2),
      .cfg_dual(cfg_dual), .cfg_delay(cfg_delay), .cfg_fs_ignore(cfg_fs_ignore),
      .cfg_fs_low(cfg_fs_low), .cfg_launch_fall(cfg_launch_fall),
      .bit_rise(bit_rise), .bit_fall(bit_fall), .fsync(fsync),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .sdo(sdo), .sync_err(sync_err), .underrun(underrun)
   );

   function automatic int blen(input logic [2:0] code);
      int t [8] = '{8, 12, 16, 20, 24, 32, 32, 32};
      return t[code];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hard_reset();
      @(negedge clk);
      rst_n = 1'b0; tx_en = 1'b0; in_valid = 1'b0;
      bit_rise = 1'b0; bit_fall = 1'b0; fsync = cfg_fs_low;
      repeat (2) @(negedge clk);
      rst_n = 1'b1; tx_en = 1'b1;
      @(negedge clk);
   endtask

   // one launch-strobe step; fs = frame sync asserted (logical level)
   task automatic step_on(input bit fs, input bit on_fall);
      @(negedge clk);
      fsync = fs ^ cfg_fs_low;
      if (on_fall) bit_fall = 1'b1; else bit_rise = 1'b1;
      @(negedge clk);
      bit_fall = 1'b0; bit_rise = 1'b0; fsync = cfg_fs_low;
   endtask

   task automatic step(input bit fs);
      step_on(fs, cfg_launch_fall);
   endtask

   task automatic push(input logic [31:0] w);
      @(negedge clk);
      in_valid = 1'b1; in_data = w;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // plays one whole frame from wq[] and compares every bit; mid_fs = bit index
   // at which an extra frame sync is applied (-1 for none)
   task automatic play_frame(input string req, input int mid_fs);
      logic exp_bits [$];
      int ne1, ne2, wi, bi, nl;
      ne1 = int'(cfg_cnt1) + 1;
      ne2 = cfg_dual ? int'(cfg_cnt2) + 1 : 0;
      for (int e = 0; e < ne1 + ne2; e++) begin
         nl = (e < ne1) ? blen(cfg_wlen1) : blen(cfg_wlen2);
         for (int b = nl - 1; b >= 0; b--) exp_bits.push_back(wq[e][b]);
      end
      wi = 0;
      push(wq[wi]); wi++;
      step(1'b1);
      bi = 0;
      if (cfg_delay) begin
         chk({req, " lead step low"}, sdo, 0);
      end else begin
         chk({req, " first bit on sync step"}, sdo, exp_bits[0]);
         bi = 1;
      end
      while (bi < exp_bits.size()) begin
         if (wi < ne1 + ne2 && in_ready) begin push(wq[wi]); wi++; end
         step(bi == mid_fs);
         chk($sformatf("%s bit %0d", req, bi), sdo, exp_bits[bi]);
         bi++;
      end
      step(1'b0);
      chk({req, " R11 low after frame"}, sdo, 0);
      chk({req, " no sync error"}, sync_err, 0);
      chk({req, " no underrun"}, underrun, 0);
   endtask

   // R11 R12: reset state
   task automatic t_reset();
      hard_reset();
      chk("R11 reset sdo", sdo, 0);
      chk("R12 reset ready", in_ready, 1);
      chk("R6 reset sync_err", sync_err, 0);
      chk("R10 reset underrun", underrun, 0);
   endtask

   // R1 R2 R4 R11: single phase, 16-bit, two elements, delay 1
   task automatic t_single();
      cfg_wlen1 = 3'd2; cfg_cnt1 = 7'd1; cfg_dual = 0; cfg_delay = 1;
      cfg_fs_ignore = 0; cfg_fs_low = 0; cfg_launch_fall = 0;
      hard_reset();
      wq[0] = 32'h0000_A5C3; wq[1] = 32'h0000_3C96;
      play_frame("R1 R2 R4 single", -1);
   endtask

   // R3 R4 R1: dual phase 8-bit x1 then 32-bit x2, delay 0
   task automatic t_dual();
      cfg_wlen1 = 3'd0; cfg_cnt1 = 7'd0; cfg_wlen2 = 3'd5; cfg_cnt2 = 7'd1;
      cfg_dual = 1; cfg_delay = 0; cfg_fs_ignore = 0; cfg_fs_low = 0; cfg_launch_fall = 0;
      hard_reset();
      wq[0] = 32'hFFFF_FF6B; wq[1] = 32'hDEAD_BEEF; wq[2] = 32'h1234_5678;
      play_frame("R3 dual 8/32", -1);
   endtask

   // R1 R8 R9: 12-bit and 24-bit phases, falling launch, active-low sync
   task automatic t_dual_fall();
      cfg_wlen1 = 3'd1; cfg_cnt1 = 7'd0; cfg_wlen2 = 3'd4; cfg_cnt2 = 7'd0;
      cfg_dual = 1; cfg_delay = 1; cfg_fs_ignore = 0; cfg_fs_low = 1; cfg_launch_fall = 1;
      hard_reset();
      wq[0] = 32'h0000_0A5F; wq[1] = 32'h00C3_5A96;
      play_frame("R1 R8 R9 dual 12/24", -1);
   endtask

   // R1: reserved code 7 acts as 32 bits; R5 mid-frame sync ignored
   task automatic t_ignore();
      cfg_wlen1 = 3'd7; cfg_cnt1 = 7'd0; cfg_dual = 0; cfg_delay = 0;
      cfg_fs_ignore = 1; cfg_fs_low = 0; cfg_launch_fall = 0;
      hard_reset();
      wq[0] = 32'h8F0F_3355;
      play_frame("R1 R5 code7 ignore", 10);
   endtask

   // R6: mid-frame sync restarts and sets the sticky flag; R7 clears it
   task automatic t_sync_err();
      cfg_wlen1 = 3'd0; cfg_cnt1 = 7'd1; cfg_dual = 0; cfg_delay = 0;
      cfg_fs_ignore = 0; cfg_fs_low = 0; cfg_launch_fall = 0;
      hard_reset();
      push(32'hC3);
      step(1'b1);
      chk("R6 first bit", sdo, 1);
      push(32'hB4);
      step(1'b0); chk("R6 bit 6", sdo, 1);
      step(1'b0); chk("R6 bit 5", sdo, 0);
      chk("R6 no error yet", sync_err, 0);
      step(1'b1);
      chk("R6 restart loads next word", sdo, 1);
      chk("R6 error set", sync_err, 1);
      step(1'b0);
      chk("R6 restarted bit 6", sdo, 0);
      chk("R6 error sticky", sync_err, 1);
      @(negedge clk); tx_en = 1'b0;
      repeat (2) @(negedge clk);
      chk("R7 disable clears error", sync_err, 0);
      chk("R7 disable sdo low", sdo, 0);
      tx_en = 1'b1;
   endtask

   // R6: sync right after the last bit starts a new frame without error
   task automatic t_back_to_back();
      cfg_wlen1 = 3'd0; cfg_cnt1 = 7'd0; cfg_dual = 0; cfg_delay = 0;
      cfg_fs_ignore = 0; cfg_fs_low = 0; cfg_launch_fall = 0;
      hard_reset();
      push(32'h81);
      step(1'b1);
      push(32'hFE);
      for (int i = 6; i >= 0; i--) begin
         step(1'b0);
         chk($sformatf("R11 frame A bit %0d", i), sdo, (8'h81 >> i) & 1);
      end
      step(1'b1);
      chk("R6 back-to-back next MSB", sdo, 1);
      chk("R6 back-to-back no error", sync_err, 0);
   endtask

   // R10: missing word repeats the previous one and flags underrun
   task automatic t_underrun();
      cfg_wlen1 = 3'd0; cfg_cnt1 = 7'd1; cfg_dual = 0; cfg_delay = 0;
      cfg_fs_ignore = 0; cfg_fs_low = 0; cfg_launch_fall = 0;
      hard_reset();
      push(32'hA6);
      chk("R12 full after push", in_ready, 0);
      step(1'b1);
      chk("R12 empty after element start", in_ready, 1);
      for (int i = 6; i >= 0; i--) step(1'b0);
      chk("R10 no underrun before second element", underrun, 0);
      step(1'b0);
      chk("R10 repeated MSB", sdo, 1);
      chk("R10 underrun set", underrun, 1);
      step(1'b0);
      chk("R10 repeated bit 6", sdo, 0);
      step(1'b0);
      chk("R10 repeated bit 5", sdo, 1);
      chk("R10 underrun sticky", underrun, 1);
   endtask

   // R7 R8 R9: disabled block ignores sync; wrong strobe and wrong level do nothing
   task automatic t_enable_edge();
      cfg_wlen1 = 3'd2; cfg_cnt1 = 7'd0; cfg_dual = 0; cfg_delay = 0;
      cfg_fs_ignore = 0; cfg_fs_low = 1; cfg_launch_fall = 1;
      hard_reset();
      push(32'h8000);
      @(negedge clk); tx_en = 1'b0;
      step(1'b1);
      chk("R7 disabled sync starts nothing", sdo, 0);
      chk("R7 word kept while disabled", in_ready, 0);
      @(negedge clk); tx_en = 1'b1;
      step(1'b0);
      chk("R9 inactive level starts nothing", sdo, 0);
      chk("R9 word not consumed", in_ready, 0);
      step_on(1'b1, 1'b0);
      chk("R8 rising strobe ignored when launching on fall", sdo, 0);
      step(1'b1);
      chk("R7 R9 start after enable", sdo, 1);
      step_on(1'b1, 1'b0);
      chk("R8 rising strobe leaves bit", sdo, 1);
      chk("R8 rising strobe no error", sync_err, 0);
      step(1'b0);
      chk("R8 falling strobe advances", sdo, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin : main
      t_reset();
      t_single();
      t_dual();
      t_dual_fall();
      t_ignore();
      t_sync_err();
      t_back_to_back();
      t_underrun();
      t_enable_edge();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule